// File: doc/BRIEF.md
# Burst Handshaking Parallel Output Controller

This block moves 32-bit words from a first-word-fall-through output FIFO onto a parallel output port. It produces a gated sample clock that pulses once for each word placed on the port. An external receiver paces the flow with a request/acknowledge pair. The block raises a request while it is running and holds data. The receiver grants transfers with an acknowledge level. When the receiver withdraws the acknowledge, the block may still send a fixed number of words (four by default), and then it stops.

A start stage decides when the block begins to run. After an arm pulse, the block either starts at once or waits for a trigger. The trigger comes from a software pulse or from the rising edge of an external trigger line; the external line is synchronized first. Sending is paced by a sample-clock enable input, so at most one word leaves per enabled cycle.

Top module: `bho_burst_out`

## Requirements
- R1: While reset is asserted the outputs are as follows: `state_o` is 0 (idle), `req_o` is low, `fifo_pop_o` is low, `clk_gate_o` is low and `dout_o` is zero.
- R2: With `start_mode_i` = 0, an `arm_i` pulse sampled in idle moves `state_o` to 2 (running) on the next cycle.
- R3: With `start_mode_i` = 1, an `arm_i` pulse moves `state_o` to 1 (waiting). The block stays in that state, and sends nothing, until a `sw_trig_i` pulse or a rising edge on `ext_trig_i` is seen. The external edge passes through two synchronizer flops, so `state_o` becomes 2 on the third clock edge after `ext_trig_i` rises.
- R4: `req_o` is high exactly when `state_o` is 2 and `fifo_empty_i` is low. When the FIFO runs empty, pops and clock pulses stop. They resume once data is present again.
- R5: No word is sent after arming until `ack_i` has been sampled high at least once while running.
- R6: `fifo_pop_o` is high only in a cycle where the block is running, `smp_en_i` is high, the FIFO is not empty and sending is permitted. In the cycle after a pop, `dout_o` holds the popped word and `clk_gate_o` is high. In every other cycle `clk_gate_o` is low. Words leave in FIFO order.
- R7: Each cycle with `ack_i` high reloads a credit of four. Each word sent while `ack_i` is low uses one credit. After `ack_i` falls, exactly four more words are sent and then transfers halt. Transfers restart when `ack_i` returns high.
- R8: `dout_o` keeps its value in every cycle that does not follow a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Arm pulse, accepted only in idle |
| start_mode_i | input | 1 | 0: run at once, 1: wait for a trigger |
| sw_trig_i | input | 1 | Software trigger pulse |
| ext_trig_i | input | 1 | Asynchronous external trigger line |
| smp_en_i | input | 1 | Sample-clock enable, one word at most per high cycle |
| ack_i | input | 1 | Receiver acknowledge level |
| fifo_empty_i | input | 1 | FIFO empty flag |
| fifo_data_i | input | 32 | FIFO head word (first-word fall-through) |
| fifo_pop_o | output | 1 | FIFO read strobe |
| req_o | output | 1 | Request: running with data available |
| dout_o | output | 32 | Registered parallel output data |
| clk_gate_o | output | 1 | Gated sample clock pulse aligned with `dout_o` |
| state_o | output | 2 | 0 idle, 1 waiting for trigger, 2 running |

## Verification
The assertions check the following on every cycle: a pop happens only under a qualified enable, a clock pulse follows every pop and only a pop, the output word matches the popped word and holds otherwise, the credit steps down by one per unacknowledged send, and the idle and running states are sticky. Only the bench scenarios can show the end-to-end counts. These are exactly four words after acknowledge falls, across several enable rates and several burst lengths before the fall, together with the pause and resume on an empty FIFO, the silence before the first acknowledge, and the three-edge latency of the external trigger.

// File: rtl/bho_pkg.sv
package bho_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } run_state_e;
endpackage

// File: rtl/bho_start.sv
module bho_start
  import bho_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic       start_mode_i,
  input  logic       sw_trig_i,
  input  logic       ext_trig_i,
  output run_state_e state_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev_q;
  logic                   ext_rise;
  logic                   trig;
  run_state_e             state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= ext_trig_i;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b0;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_prev_q <= 1'b0;
    else         ext_prev_q <= sync_q[LAST];
  end

  assign ext_rise = sync_q[LAST] & ~ext_prev_q;
  assign trig     = sw_trig_i | ext_rise;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (arm_i) state_d = start_mode_i ? ST_WAIT : ST_RUN;
      ST_WAIT: if (trig)  state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !arm_i) |=> state_q == ST_IDLE);

  // R3
  wait_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !sw_trig_i && !sync_q[LAST]) |=> state_q == ST_WAIT);

  // R2
  run_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN |=> state_q == ST_RUN);
endmodule

// File: rtl/bho_credit.sv
module bho_credit #(
  parameter int CREDITS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ack_i,
  input  logic send_i,
  output logic permit_o
);
  localparam int CW = $clog2(CREDITS + 1);

  logic [CW-1:0] credit_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit_q <= CW'(CREDITS);
      seen_q   <= 1'b0;
    end else begin
      if (run_i && ack_i) seen_q <= 1'b1;
      if (ack_i)       credit_q <= CW'(CREDITS);
      else if (send_i) credit_q <= credit_q - 1'b1;
    end
  end

  // live ack always permits; after withdrawal only remaining credit does
  assign permit_o = ack_i | (seen_q & (credit_q != '0));

  // R7
  credit_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_i && !ack_i) |=> credit_q == CW'($past(credit_q) - 1'b1));

  // R7
  credit_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    credit_q <= CW'(CREDITS));
endmodule

// File: rtl/bho_out.sv
module bho_out #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] dout_o,
  output logic          gate_o
);
  logic [DW-1:0] dout_q;
  logic          gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= load_i;
      if (load_i) dout_q <= data_i;
    end
  end

  assign dout_o = dout_q;
  assign gate_o = gate_q;
endmodule

// File: rtl/bho_burst_out.sv
module bho_burst_out
  import bho_pkg::*;
#(
  parameter int DW          = 32,
  parameter int CREDITS     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          start_mode_i,
  input  logic          sw_trig_i,
  input  logic          ext_trig_i,
  input  logic          smp_en_i,
  input  logic          ack_i,
  input  logic          fifo_empty_i,
  input  logic [DW-1:0] fifo_data_i,
  output logic          fifo_pop_o,
  output logic          req_o,
  output logic [DW-1:0] dout_o,
  output logic          clk_gate_o,
  output logic [1:0]    state_o
);
  run_state_e state;
  logic       run;
  logic       permit;
  logic       send;

  bho_start #(.SYNC_STAGES(SYNC_STAGES)) u_start (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm_i),
    .start_mode_i(start_mode_i),
    .sw_trig_i   (sw_trig_i),
    .ext_trig_i  (ext_trig_i),
    .state_o     (state)
  );

  assign run  = (state == ST_RUN);
  assign send = run & smp_en_i & ~fifo_empty_i & permit;

  bho_credit #(.CREDITS(CREDITS)) u_credit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .ack_i   (ack_i),
    .send_i  (send),
    .permit_o(permit)
  );

  bho_out #(.DW(DW)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(send),
    .data_i(fifo_data_i),
    .dout_o(dout_o),
    .gate_o(clk_gate_o)
  );

  assign fifo_pop_o = send;
  assign req_o      = run & ~fifo_empty_i;
  assign state_o    = state;

  // R6
  pop_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> (smp_en_i && !fifo_empty_i && state_o == 2'd2));

  // R6
  gate_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> clk_gate_o);

  // R6
  gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_pop_o |=> !clk_gate_o);

  // R6
  data_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> dout_o == $past(fifo_data_i));

  // R8
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_pop_o |=> $stable(dout_o));

  // R4
  req_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_empty_i |-> (!req_o && !fifo_pop_o));
endmodule

// File: tb/tb_bho_burst_out.sv
module tb_bho_burst_out;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        arm = 1'b0, mode = 1'b0, sw_trig = 1'b0, ext_trig = 1'b0;
  logic        smp_en = 1'b0, ack = 1'b0, clr = 1'b1;
  logic        fifo_pop, req, clk_gate;
  logic [31:0] dout;
  logic [1:0]  state;
  int unsigned rd_ptr = 0, level = 0, exp_idx = 0;
  int          dv = 1, ph = 0;
  int          nchk = 0, nerr = 0;

  wire         fifo_empty = (rd_ptr >= level);
  wire  [31:0] fifo_data  = 32'hA000_0000 + rd_ptr;

  always #2 clk = ~clk;

  bho_burst_out dut (
    .clk_i(clk), .rst_ni(rst_ni), .arm_i(arm), .start_mode_i(mode),
    .sw_trig_i(sw_trig), .ext_trig_i(ext_trig), .smp_en_i(smp_en),
    .ack_i(ack), .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data),
    .fifo_pop_o(fifo_pop), .req_o(req), .dout_o(dout),
    .clk_gate_o(clk_gate), .state_o(state)
  );

  // FIFO model and sample-enable pacing
  always @(posedge clk) begin
    if (clr) rd_ptr <= 0;
    else if (fifo_pop) rd_ptr <= rd_ptr + 1;
  end

  always @(posedge clk) begin
    #1;
    ph = (ph + 1) % dv;
    smp_en = (ph == 0);
  end

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // every clock pulse carries the next word in FIFO order (R6)
  always @(negedge clk) begin
    if (clr) exp_idx <= 0;
    else if (clk_gate) begin
      check(dout == 32'hA000_0000 + exp_idx, "R6", dout, 32'hA000_0000 + exp_idx);
      exp_idx <= exp_idx + 1;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; clr = 1'b1;
    arm = 0; mode = 0; sw_trig = 0; ext_trig = 0; ack = 0; level = 0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1; clr = 1'b0;
  endtask

  task automatic arm_block(input logic m);
    mode = m; arm = 1'b1;
    tick();
    arm = 1'b0;
  endtask

  task automatic run_burst(input int div, input int pre);
    int unsigned base;
    logic [31:0] held;
    do_reset();
    dv = div; level = 200;
    arm_block(1'b0);
    repeat (10) tick();
    @(negedge clk);
    check(rd_ptr == 0, "R5", rd_ptr, 0);
    check(req == 1'b1, "R4", req, 1);
    tick();
    ack = 1'b1;
    for (int g = 0; g < 60; g++) begin
      tick();
      if (rd_ptr >= pre) break;
    end
    ack = 1'b0;
    base = rd_ptr;
    repeat (40) tick();
    @(negedge clk);
    check(rd_ptr - base == 4, "R7", rd_ptr - base, 4);
    check(clk_gate == 1'b0, "R7", clk_gate, 0);
    held = dout;
    tick();
    @(negedge clk);
    check(dout == held, "R8", dout, held);
    tick();
    ack = 1'b1;
    repeat (12) tick();
    check(rd_ptr > base + 4, "R7", rd_ptr, base + 5);
  endtask

  initial begin
    #(4 * 150000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    do_reset();
    rst_ni = 1'b0;
    @(negedge clk);
    // R1
    check(state == 2'd0, "R1", state, 0);
    check(req == 1'b0 && fifo_pop == 1'b0, "R1", {req, fifo_pop}, 0);
    check(clk_gate == 1'b0 && dout == 32'h0, "R1", dout, 0);
    #1 rst_ni = 1'b1;

    // R2 immediate start
    do_reset();
    arm_block(1'b0);
    @(negedge clk);
    check(state == 2'd2, "R2", state, 2);

    // R3 software trigger
    do_reset();
    level = 50; dv = 1;
    arm_block(1'b1);
    @(negedge clk);
    check(state == 2'd1, "R3", state, 1);
    tick();
    ack = 1'b1;
    repeat (10) tick();
    @(negedge clk);
    check(state == 2'd1 && rd_ptr == 0, "R3", rd_ptr, 0);
    tick();
    sw_trig = 1'b1; tick(); sw_trig = 1'b0;
    @(negedge clk);
    check(state == 2'd2, "R3", state, 2);
    repeat (5) tick();
    check(rd_ptr > 0, "R3", rd_ptr, 1);

    // R3 external trigger, two-flop latency
    do_reset();
    arm_block(1'b1);
    ext_trig = 1'b1;
    tick();
    @(negedge clk);
    check(state == 2'd1, "R3", state, 1);
    tick(); tick();
    @(negedge clk);
    check(state == 2'd2, "R3", state, 2);

    // R4 FIFO drains, then refills
    do_reset();
    dv = 1; level = 3;
    arm_block(1'b0);
    ack = 1'b1;
    repeat (20) tick();
    @(negedge clk);
    check(rd_ptr == 3, "R4", rd_ptr, 3);
    check(req == 1'b0 && clk_gate == 1'b0, "R4", {req, clk_gate}, 0);
    tick();
    level = 6;
    @(negedge clk);
    check(req == 1'b1, "R4", req, 1);
    repeat (20) tick();
    check(rd_ptr == 6, "R4", rd_ptr, 6);

    // R5 R7 R8 sweep over enable rate and pre-drop burst length
    for (int d = 1; d <= 3; d++)
      for (int p = 0; p <= 4; p++)
        run_burst(d, p);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule